// File: doc/BRIEF.md
# Receive Frame Ring Writer

This block takes received Ethernet frames from a byte stream and stores them in a circular region of a local buffer RAM, which is 32 KB with the default address width. Each stored frame begins with a four-word header that host software reads to walk the ring. The words are a completion event, a status word with error flags, the address of the next frame, and a byte count. The ring bounds are given as two page numbers of 256 bytes each. The last usable word of the ring sits at byte 0xFE of the upper page.

The host frees space by moving a stop pointer forward. The writer never writes the word just past that pointer. A frame that would need that word is dropped, and a drop counter is incremented. The host can ask for errored frames to be discarded, in which case their space is reused at once. Each good frame that is committed raises a one-cycle receive interrupt, unless the interrupt is masked. RAM writes are 16-bit words at even byte addresses.

Top module: `rx_ring_writer`

## Requirements
- R1: A frame at base address B has its header words at B, B+2, B+4 and B+6, in the order event, status, next-frame address, byte count. Data words start at B+8. The first byte of each byte pair goes in bits 7:0 and the second in bits 15:8. An odd final byte is written with a zero high byte. Every RAM write uses an even address.
- R2: The event word of a frame is set to 0x0008 as the last write of that frame's commit. Until then the word holds 0x0000, because the previous frame's commit, or the ring initialisation, wrote 0x0000 there, replacing any stale value.
- R3: In the status word, bit 13 is set only when the frame carries no error. The five error inputs err[0..4] are copied to status bits 0, 7, 8, 10 and 11.
- R4: The count word holds the frame's byte count in bits 13:0, with bits 15:14 at zero.
- R5: After the word at (upper page, 0xFE), the next address used is (lower page, 0x00). This applies both to data and to headers. The next-frame word is the word address that follows the frame's last data word, after this wrap. That address becomes the base of the following frame. No write falls outside the ring bounds.
- R6: A ring-init pulse sets the frame base to the lower-limit page start and writes 0x0000 to that address.
- R7: Let G be the word that follows (stop pointer with bit 0 cleared), after wrapping. The writer never writes G. A frame whose header words 2–6, data words or next-frame word would land on G is dropped. The drop counter then increases by exactly one, nothing is committed, and the next frame reuses the same base.
- R8: When discard is enabled, a frame with any error flag writes no header, raises no interrupt and leaves the base unchanged. When discard is disabled, an errored frame is committed with its error flags set.
- R9: The interrupt output is a one-cycle pulse that coincides with the 0x0008 event write of an error-free frame. It stays low when the receive mask input was high in the commit cycle.
- R10: A byte presented while idle without a start marker is ignored and causes no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_init_i | input | 1 | Reset the frame base to the ring start |
| lo_page_i | input | ADDR_W-8 | Lower ring limit, in 256-byte pages |
| hi_page_i | input | ADDR_W-8 | Upper ring limit, in 256-byte pages |
| stop_ptr_i | input | ADDR_W | Host stop pointer, the byte just below the oldest unread data |
| discard_bad_i | input | 1 | Drop frames that carry errors |
| rx_mask_i | input | 1 | Suppress the receive interrupt |
| rx_valid_i | input | 1 | Byte valid |
| rx_sof_i | input | 1 | First byte of a frame |
| rx_eof_i | input | 1 | Last byte of a frame |
| rx_data_i | input | 8 | Frame byte |
| rx_err_i | input | 5 | Error flags, sampled with the last byte |
| mem_we_o | output | 1 | RAM word write enable |
| mem_addr_o | output | ADDR_W | RAM byte address, always even |
| mem_wdata_o | output | 16 | RAM write data |
| rx_irq_o | output | 1 | Receive interrupt pulse |
| drop_cnt_o | output | CNT_W | Count of frames dropped for lack of space |

## Verification
The frames cover even and odd lengths, which separates full-word packing from the zero-padded final word. One long frame crosses the upper limit and shows whether data and the next-frame pointer wrap to the lower page. Frames with errors are sent once with discard off and once with discard on, which separates committing a frame with its flags from reusing its space. Two placements of the stop pointer are used, one cutting into the data and one into the header, so both overflow paths are exercised. A masked frame and stray bytes outside a frame complete the set.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int ERR_W = 5;
  localparam int LEN_W = 14;
  localparam int GOOD_BIT = 13;
  localparam logic [15:0] EVT_DONE  = 16'h0008;
  localparam logic [15:0] EVT_EMPTY = 16'h0000;

  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_DROP, S_FIN, S_STAT, S_NEXT, S_CNT, S_EVT
  } wr_state_e;

  function automatic logic [15:0] status_word(input logic [ERR_W-1:0] e);
    logic [15:0] w;
    w = '0;
    w[0]  = e[0];
    w[7]  = e[1];
    w[8]  = e[2];
    w[10] = e[3];
    w[11] = e[4];
    w[GOOD_BIT] = (e == '0);
    return w;
  endfunction
endpackage

// File: rtl/rx_ring_wrap.sv
module rx_ring_wrap #(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        step_i,
  input  logic [ADDR_W-9:0] lo_page_i,
  input  logic [ADDR_W-9:0] hi_page_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W:0] sum, top, span;

  assign top  = {1'b0, hi_page_i, 8'hFE};
  assign span = top + (ADDR_W+1)'(2) - {1'b0, lo_page_i, 8'h00};
  assign sum  = {1'b0, addr_i} + {{(ADDR_W-3){1'b0}}, step_i};

  always_comb begin
    if (sum > top) addr_o = ADDR_W'(sum - span);
    else           addr_o = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/rx_ring_packer.sv
module rx_ring_packer (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic       take_i,
  input  logic [7:0] byte_i,
  output logic       odd_o,
  output logic [7:0] lo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_o <= 1'b0;
      lo_o  <= '0;
    end else if (load_i) begin
      odd_o <= 1'b1;
      lo_o  <= byte_i;
    end else if (take_i || clr_i) begin
      odd_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [ADDR_W-9:0] lo_page_i,
  input  logic [ADDR_W-9:0] hi_page_i,
  input  logic [ADDR_W-1:0] stop_ptr_i,
  input  logic              discard_bad_i,
  input  logic              rx_mask_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  input  logic              odd_i,
  input  logic [7:0]        lo_i,
  output logic              load_o,
  output logic              take_o,
  output logic              clr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  output logic              rx_irq_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  localparam int HDR_WORDS = 4;

  wr_state_e         state_q;
  logic [ADDR_W-1:0] base_q, dptr_q, waddr_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [ERR_W-1:0]  err_q;
  logic [CNT_W-1:0]  drop_q;
  logic [15:0]       wdata_q;
  logic              we_q, irq_q;

  logic [ADDR_W-1:0] hdr_addr [1:HDR_WORDS];
  logic [ADDR_W-1:0] step_ptr, stop_w, guard, start_addr;
  logic              hdr_hit, discard_now, drop_now;

  for (genvar k = 1; k <= HDR_WORDS; k++) begin : g_hdr
    rx_ring_wrap #(.ADDR_W(ADDR_W)) u_hdr (
      .addr_i(base_q), .step_i(4'(2*k)),
      .lo_page_i(lo_page_i), .hi_page_i(hi_page_i), .addr_o(hdr_addr[k])
    );
  end

  rx_ring_wrap #(.ADDR_W(ADDR_W)) u_step (
    .addr_i(dptr_q), .step_i(4'd2),
    .lo_page_i(lo_page_i), .hi_page_i(hi_page_i), .addr_o(step_ptr)
  );

  assign stop_w = stop_ptr_i & ~ADDR_W'(1);

  rx_ring_wrap #(.ADDR_W(ADDR_W)) u_guard (
    .addr_i(stop_w), .step_i(4'd2),
    .lo_page_i(lo_page_i), .hi_page_i(hi_page_i), .addr_o(guard)
  );

  assign start_addr  = {lo_page_i, 8'h00};
  assign hdr_hit     = (hdr_addr[1] == guard) || (hdr_addr[2] == guard) ||
                       (hdr_addr[3] == guard);
  assign discard_now = discard_bad_i && (err_q != '0);

  always_comb begin
    drop_now = 1'b0;
    if (!init_i) begin
      unique case (state_q)
        S_IDLE:  drop_now = rx_valid_i && rx_sof_i && hdr_hit;
        S_RECV:  drop_now = rx_valid_i && odd_i && (dptr_q == guard);
        S_FIN:   drop_now = !discard_now && (dptr_q == guard);
        default: drop_now = 1'b0;
      endcase
    end
  end

  assign load_o = !init_i && rx_valid_i &&
                  ((state_q == S_IDLE && rx_sof_i) || (state_q == S_RECV && !odd_i));
  assign take_o = (state_q == S_RECV && rx_valid_i && odd_i) || (state_q == S_FIN);
  assign clr_o  = init_i || (state_q == S_IDLE) || (state_q == S_DROP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      dptr_q  <= '0;
      cnt_q   <= '0;
      err_q   <= '0;
      drop_q  <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      we_q  <= 1'b0;
      irq_q <= 1'b0;
      if (drop_now) drop_q <= drop_q + CNT_W'(1);
      if (init_i) begin
        state_q <= S_IDLE;
        base_q  <= start_addr;
        we_q    <= 1'b1;
        waddr_q <= start_addr;
        wdata_q <= EVT_EMPTY;
      end else begin
        unique case (state_q)
          S_IDLE: begin
            if (rx_valid_i && rx_sof_i) begin
              if (hdr_hit) begin
                state_q <= rx_eof_i ? S_IDLE : S_DROP;
              end else begin
                dptr_q <= hdr_addr[4];
                cnt_q  <= LEN_W'(1);
                if (rx_eof_i) begin
                  err_q   <= rx_err_i;
                  state_q <= S_FIN;
                end else begin
                  state_q <= S_RECV;
                end
              end
            end
          end
          S_RECV: begin
            if (rx_valid_i) begin
              cnt_q <= cnt_q + LEN_W'(1);
              if (odd_i && dptr_q == guard) begin
                state_q <= rx_eof_i ? S_IDLE : S_DROP;
              end else begin
                if (odd_i) begin
                  we_q    <= 1'b1;
                  waddr_q <= dptr_q;
                  wdata_q <= {rx_data_i, lo_i};
                  dptr_q  <= step_ptr;
                end
                if (rx_eof_i) begin
                  err_q   <= rx_err_i;
                  state_q <= S_FIN;
                end
              end
            end
          end
          S_DROP: begin
            if (rx_valid_i && rx_eof_i) state_q <= S_IDLE;
          end
          S_FIN: begin
            if (discard_now || dptr_q == guard) begin
              state_q <= S_IDLE;
            end else if (odd_i) begin
              we_q    <= 1'b1;
              waddr_q <= dptr_q;
              wdata_q <= {8'h00, lo_i};
              dptr_q  <= step_ptr;
            end else begin
              // clear the following frame's event word before this one commits
              we_q    <= 1'b1;
              waddr_q <= dptr_q;
              wdata_q <= EVT_EMPTY;
              state_q <= S_STAT;
            end
          end
          S_STAT: begin
            we_q    <= 1'b1;
            waddr_q <= hdr_addr[1];
            wdata_q <= status_word(err_q);
            state_q <= S_NEXT;
          end
          S_NEXT: begin
            we_q    <= 1'b1;
            waddr_q <= hdr_addr[2];
            wdata_q <= 16'(dptr_q);
            state_q <= S_CNT;
          end
          S_CNT: begin
            we_q    <= 1'b1;
            waddr_q <= hdr_addr[3];
            wdata_q <= {2'b00, cnt_q};
            state_q <= S_EVT;
          end
          S_EVT: begin
            we_q    <= 1'b1;
            waddr_q <= base_q;
            wdata_q <= EVT_DONE;
            base_q  <= dptr_q;
            irq_q   <= (err_q == '0) && !rx_mask_i;
            state_q <= S_IDLE;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_we_o    = we_q;
  assign mem_addr_o  = waddr_q;
  assign mem_wdata_o = wdata_q;
  assign rx_irq_o    = irq_q;
  assign drop_cnt_o  = drop_q;

  p_no_guard_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && !$past(init_i) && ($past(state_q) == S_RECV || $past(state_q) == S_FIN))
      |-> (waddr_q != $past(guard)));

  p_drop_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_q != $past(drop_q)) |-> (drop_q == $past(drop_q) + CNT_W'(1)));

  p_evt_after_cnt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EVT) |-> ($past(state_q) == S_CNT));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ring_init_i,
  input  logic [ADDR_W-9:0] lo_page_i,
  input  logic [ADDR_W-9:0] hi_page_i,
  input  logic [ADDR_W-1:0] stop_ptr_i,
  input  logic              discard_bad_i,
  input  logic              rx_mask_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  input  logic [4:0]        rx_err_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  output logic              rx_irq_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  logic       odd, load, take, clr;
  logic [7:0] lo_byte;

  rx_ring_packer u_packer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .load_i(load), .take_i(take),
    .byte_i(rx_data_i), .odd_o(odd), .lo_o(lo_byte)
  );

  rx_ring_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(ring_init_i),
    .lo_page_i(lo_page_i), .hi_page_i(hi_page_i), .stop_ptr_i(stop_ptr_i),
    .discard_bad_i(discard_bad_i), .rx_mask_i(rx_mask_i),
    .rx_valid_i(rx_valid_i), .rx_sof_i(rx_sof_i), .rx_eof_i(rx_eof_i),
    .rx_data_i(rx_data_i), .rx_err_i(rx_err_i),
    .odd_i(odd), .lo_i(lo_byte), .load_o(load), .take_o(take), .clr_o(clr),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .rx_irq_o(rx_irq_o), .drop_cnt_o(drop_cnt_o)
  );

  p_word_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_addr_o[0]);

  p_in_ring_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o >= {lo_page_i, 8'h00} && mem_addr_o <= {hi_page_i, 8'hFE}));

  p_irq_on_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> (mem_we_o && mem_wdata_o == EVT_DONE));

  p_irq_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> !$past(rx_mask_i));

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);
endmodule

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;
  localparam logic [15:0] RS = 16'h1000;
  localparam logic [15:0] RE = 16'h11FE;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, init, discard, mask, valid, sof, eof;
  logic [7:0]  data;
  logic [4:0]  err;
  logic [15:0] stop;
  logic        mem_we_o, rx_irq_o;
  logic [14:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [7:0]  drop_cnt_o;

  int checks = 0, errors = 0, irq_cnt = 0, wr_cnt = 0;
  logic [15:0] mem [int];
  logic [15:0] base;

  rx_ring_writer dut (
    .clk_i(clk), .rst_ni(rst_n), .ring_init_i(init),
    .lo_page_i(7'h10), .hi_page_i(7'h11), .stop_ptr_i(stop[14:0]),
    .discard_bad_i(discard), .rx_mask_i(mask),
    .rx_valid_i(valid), .rx_sof_i(sof), .rx_eof_i(eof),
    .rx_data_i(data), .rx_err_i(err),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .rx_irq_o(rx_irq_o), .drop_cnt_o(drop_cnt_o)
  );

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_we_o) begin
      mem[int'(mem_addr_o)] = mem_wdata_o;
      wr_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rx_irq_o) begin
      irq_cnt++;
      chk("R9 irq coincides with event write", {15'd0, mem_we_o, mem_wdata_o}, {15'd0, 1'b1, 16'h0008});
    end
  end

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'hDEAD;
  endfunction

  function automatic logic [15:0] nx(input logic [15:0] a);
    return (a == RE) ? RS : a + 16'd2;
  endfunction

  function automatic logic [15:0] guard_of(input logic [15:0] s);
    return nx(s & 16'hFFFE);
  endfunction

  function automatic logic [15:0] exp_status(input logic [4:0] e);
    logic [15:0] w;
    w = 16'h0000;
    if (e[0]) w = w | 16'h0001;
    if (e[1]) w = w | 16'h0080;
    if (e[2]) w = w | 16'h0100;
    if (e[3]) w = w | 16'h0400;
    if (e[4]) w = w | 16'h0800;
    if (e == 5'd0) w = w | 16'h2000;
    return w;
  endfunction

  function automatic logic predict_drop(input logic [15:0] b, input int len, input logic [15:0] s);
    logic [15:0] g, a;
    g = guard_of(s);
    a = b;
    for (int i = 0; i < 3; i++) begin
      a = nx(a);
      if (a == g) return 1'b1;
    end
    for (int j = 0; j < (len + 1) / 2; j++) begin
      a = nx(a);
      if (a == g) return 1'b1;
    end
    a = nx(a);
    return (a == g);
  endfunction

  task automatic send_frame(input int len, input logic [7:0] seed, input logic [4:0] e, input bit mid);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (mid && k == len / 2)
        chk("R2 event word zero while frame in flight", {16'd0, rd(base)}, 32'h0);
      valid = 1'b1;
      sof   = (k == 0);
      eof   = (k == len - 1);
      data  = seed + 8'(k);
      err   = (k == len - 1) ? e : 5'd0;
    end
    @(negedge clk);
    valid = 1'b0; sof = 1'b0; eof = 1'b0; err = 5'd0;
    repeat (12) @(negedge clk);
  endtask

  task automatic run_frame(input string name, input int len, input logic [7:0] seed,
                           input logic [4:0] e, input bit mid);
    logic ovf, bad, commit;
    logic [15:0] h1, h2, h3, a, w;
    int i0, d0, mism;
    ovf    = predict_drop(base, len, stop);
    bad    = (e != 5'd0);
    commit = !ovf && !(bad && discard);
    i0 = irq_cnt;
    d0 = int'(drop_cnt_o);
    send_frame(len, seed, e, mid);
    if (commit) begin
      h1 = nx(base); h2 = nx(h1); h3 = nx(h2);
      a = h3; mism = 0;
      for (int j = 0; j < (len + 1) / 2; j++) begin
        a = nx(a);
        w[7:0]  = seed + 8'(2 * j);
        w[15:8] = (2 * j + 1 < len) ? seed + 8'(2 * j + 1) : 8'h00;
        if (rd(a) !== w) mism++;
      end
      a = nx(a);
      chk({name, " R1 data words packed"}, mism, 0);
      chk({name, " R2 event word done"}, {16'd0, rd(base)}, 32'h0008);
      chk({name, " R3 status word"}, {16'd0, rd(h1)}, {16'd0, exp_status(e)});
      chk({name, " R5 next pointer"}, {16'd0, rd(h2)}, {16'd0, a});
      chk({name, " R4 byte count"}, {16'd0, rd(h3)}, 32'(len & 16'h3FFF));
      chk({name, " R2 next event word cleared"}, {16'd0, rd(a)}, 32'h0);
      base = a;
    end else begin
      chk({name, " R8 event word not committed"}, {16'd0, rd(base)}, 32'h0);
    end
    chk({name, " R7 drop counter"}, int'(drop_cnt_o), d0 + int'(ovf));
    chk({name, " R9 irq count"}, irq_cnt - i0, int'(commit && !bad && !mask));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; init = 1'b0; discard = 1'b0; mask = 1'b0;
    valid = 1'b0; sof = 1'b0; eof = 1'b0; data = 8'h00; err = 5'd0;
    stop = 16'h11FE;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset irq low", {31'd0, rx_irq_o}, 0);
    chk("R7 reset drop counter", {24'd0, drop_cnt_o}, 0);
    chk("R10 reset no write", {31'd0, mem_we_o}, 0);
  endtask

  task automatic t_init();
    mem[int'(RS)] = 16'hBEEF;
    @(negedge clk) init = 1'b1;
    @(negedge clk) init = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 init clears ring start event", {16'd0, rd(RS)}, 32'h0);
    base = RS;
  endtask

  task automatic t_stray();
    int w0;
    w0 = wr_cnt;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      valid = 1'b1; sof = 1'b0; eof = (k == 3); data = 8'hA0 + 8'(k);
    end
    @(negedge clk);
    valid = 1'b0; eof = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 stray bytes make no write", wr_cnt - w0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_init();
    mem[32'h100E] = 16'h0008;
    run_frame("even", 6, 8'h10, 5'd0, 1'b0);
    run_frame("odd", 201, 8'h40, 5'd0, 1'b1);
    run_frame("err_kept", 11, 8'h22, 5'b10010, 1'b0);
    discard = 1'b1;
    run_frame("err_dropped", 20, 8'h33, 5'b00101, 1'b0);
    mask = 1'b1;
    run_frame("masked", 30, 8'h55, 5'd0, 1'b0);
    mask = 1'b0;
    run_frame("overflow", 240, 8'h77, 5'd0, 1'b0);
    stop = 16'h10DF;
    run_frame("wrap", 240, 8'h77, 5'd0, 1'b0);
    t_stray();
    stop = base + 16'd1;
    run_frame("hdr_overflow", 2, 8'h90, 5'd0, 1'b0);
    stop = 16'h11FF;
    run_frame("after_free", 4, 8'hC0, 5'd0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule